// File: doc/BRIEF.md
# Auto-Increment Word Program Sequencer

This block writes a buffer of bytes into a serial NOR flash that can program two bytes per command and advance the address by itself. A client gives a start address and a byte count, then supplies the bytes on a valid/ready stream. The block splits the write into three phases. An odd start address gets a single-byte program first. The even-aligned body goes out as two-byte auto-increment words, and only the first of these carries an address. A byte left over at the end gets one more single-byte program.

Each command goes out one byte at a time on a command port. A downstream serializer drives chip select and the clock. It ends a command after the beat marked last, and it returns one byte for every beat marked as a read. After every program command the block polls the device status until the busy bit clears. It ends the auto-increment mode with write-disable. It stops with an error flag if the device stays busy for too long. The block counts the bytes that are confirmed written. A request that would run past the end of the device is rejected before any command is sent.

Top module: `aai_word_programmer`

## Requirements
- R1: A request whose start address plus length is greater than DEV_BYTES sends no command beat and takes no data byte. It ends with done, err_range=1 and bytes_written=0. A request that ends exactly at DEV_BYTES is accepted.
- R2: If the start address is odd and the length is nonzero, the block first sends write-enable (one beat, 0x06). It then sends byte program 0x02, followed by address bits 23:16, 15:8 and 7:0 and the first data byte. After the poll it advances the address by one.
- R3: Before the first word, the block sends one write-enable (0x06). The first word command is 0xAD, then the three address bytes (high first), then two data bytes in stream order.
- R4: Every later word command is 0xAD followed by two data bytes, with no address and no write-enable before it.
- R5: After every program command, and after the write-disable that follows the words, the block polls status. A poll command is the beat 0x05 followed by one read beat of byte 0x00 with both cmd_rd and cmd_last set. The poll repeats while the returned byte has bit 0 set and ends on the first response with bit 0 clear.
- R6: If at least one word was sent, the last word's poll is followed by write-disable (one beat, 0x04) and another poll. If no word was sent, no write-disable is sent at this point.
- R7: If one byte remains after the words, the block sends write-enable, then byte program 0x02 with the full address of that byte (start+length-1) and the byte itself, then a poll, then write-disable 0x04 with no poll after it.
- R8: If MAX_POLLS responses in a row all report busy, no further command beat is sent. The request ends with done and err_timeout=1.
- R9: bytes_written counts the data bytes whose program command has been confirmed idle by a poll. It equals the length on success, and on a timeout it holds the bytes confirmed before the timeout.
- R10: A zero-length request sends no command, takes no data and ends with done and no error flag set.
- R11: A command beat held while cmd_ready is low keeps its byte, last and read markings. A data byte is consumed only in a cycle where in_valid and in_ready are both high.
- R12: done is a single-cycle pulse, after which req_ready is high again. req_ready is high only while idle, and no command or data handshake happens while idle. err_range and err_timeout stay unchanged while idle, until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_addr | input | 24 | Start byte address |
| req_len | input | LEN_W | Number of bytes to write |
| in_valid | input | 1 | Data byte present |
| in_ready | output | 1 | Block takes a data byte |
| in_data | input | 8 | Data byte |
| cmd_valid | output | 1 | Command beat present |
| cmd_ready | input | 1 | Serializer takes the beat |
| cmd_byte | output | 8 | Command beat value |
| cmd_last | output | 1 | Final beat of the command |
| cmd_rd | output | 1 | Beat is a read slot that returns a byte |
| rsp_valid | input | 1 | Returned byte present |
| rsp_byte | input | 8 | Returned status byte, bit 0 busy |
| done | output | 1 | One-cycle end-of-request pulse |
| err_range | output | 1 | Last request rejected for range |
| err_timeout | output | 1 | Last request aborted on poll limit |
| bytes_written | output | LEN_W | Confirmed bytes of the last request |

## Verification
The assertions check the following on every cycle: beats held under back-pressure stay stable, read beats are always final beats carrying 0x00, the block stays quiet while idle, done lasts one cycle, the byte count never falls during a request and never passes the accepted length, and the error flags hold steady while idle. The exact command order can only be shown by the bench scenarios. This covers the leading and trailing single-byte programs, one write-enable before the words, the address only on the first word, write-disable placement, poll counts under a given busy pattern, the point where a timeout stops the stream, and the data bytes appearing in order. The bench model builds that stream on its own and compares it beat by beat.

// File: rtl/aai_prog_pkg.sv
package aai_prog_pkg;

    localparam int ADDR_W = 24;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_BYTE = 8'h02;
    localparam logic [7:0] OP_WORD = 8'hAD;
    localparam logic [7:0] OP_STAT = 8'h05;
    localparam logic [7:0] STAT_BUSY_MASK = 8'h01;

    typedef enum logic [2:0] {
        CK_WREN, CK_WRDI, CK_BYTE, CK_WORD_A, CK_WORD, CK_STAT
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e         kind;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        d0;
        logic [7:0]        d1;
    } cmd_req_t;

    typedef enum logic [1:0] {SH_IDLE, SH_SEND, SH_RESP} shift_state_e;

    typedef enum logic [3:0] {
        S_IDLE, S_PLAN, S_ISSUE, S_CMD, S_POLL_GO, S_POLL_CHK,
        S_GET_BYTE, S_GET0, S_GET1, S_DONE
    } seq_state_e;

    typedef enum logic [1:0] {PH_LEAD, PH_WORD, PH_TAIL, PH_FIN} phase_e;

    function automatic logic [2:0] cmd_beats(cmd_kind_e k);
        case (k)
            CK_BYTE:   return 3'd5;
            CK_WORD_A: return 3'd6;
            CK_WORD:   return 3'd3;
            CK_STAT:   return 3'd2;
            default:   return 3'd1;
        endcase
    endfunction

    function automatic logic [7:0] cmd_opcode(cmd_kind_e k);
        case (k)
            CK_WREN:            return OP_WREN;
            CK_WRDI:            return OP_WRDI;
            CK_BYTE:            return OP_BYTE;
            CK_WORD_A, CK_WORD: return OP_WORD;
            default:            return OP_STAT;
        endcase
    endfunction

    function automatic logic [7:0] cmd_byte_at(cmd_req_t c, logic [2:0] idx);
        logic [7:0] op;
        op = cmd_opcode(c.kind);
        case (c.kind)
            CK_BYTE, CK_WORD_A: begin
                case (idx)
                    3'd0:    return op;
                    3'd1:    return c.addr[23:16];
                    3'd2:    return c.addr[15:8];
                    3'd3:    return c.addr[7:0];
                    3'd4:    return c.d0;
                    default: return c.d1;
                endcase
            end
            CK_WORD: begin
                case (idx)
                    3'd0:    return op;
                    3'd1:    return c.d0;
                    default: return c.d1;
                endcase
            end
            default: return (idx == 3'd0) ? op : 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/aai_cmd_shifter.sv
module aai_cmd_shifter
    import aai_prog_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  cmd_req_t   req,
    output logic       cmd_valid,
    input  logic       cmd_ready,
    output logic [7:0] cmd_byte,
    output logic       cmd_last,
    output logic       cmd_rd,
    input  logic       rsp_valid,
    input  logic [7:0] rsp_byte,
    output logic       sh_done,
    output logic       sh_busy_bit
);

    shift_state_e st_q;
    cmd_req_t     cur_q;
    logic [2:0]   idx_q;
    logic         last_w;

    assign last_w    = (idx_q == cmd_beats(cur_q.kind) - 3'd1);
    assign cmd_valid = (st_q == SH_SEND);
    assign cmd_byte  = cmd_byte_at(cur_q, idx_q);
    assign cmd_last  = last_w;
    assign cmd_rd    = (cur_q.kind == CK_STAT) && last_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= SH_IDLE;
            cur_q       <= '0;
            idx_q       <= '0;
            sh_done     <= 1'b0;
            sh_busy_bit <= 1'b0;
        end else begin
            sh_done <= 1'b0;
            case (st_q)
                SH_IDLE: begin
                    if (go) begin
                        cur_q <= req;
                        idx_q <= '0;
                        st_q  <= SH_SEND;
                    end
                end
                SH_SEND: begin
                    if (cmd_ready) begin
                        if (last_w) begin
                            if (cur_q.kind == CK_STAT) begin
                                st_q <= SH_RESP;
                            end else begin
                                st_q    <= SH_IDLE;
                                sh_done <= 1'b1;
                            end
                        end else begin
                            idx_q <= idx_q + 3'd1;
                        end
                    end
                end
                default: begin
                    if (rsp_valid) begin
                        sh_busy_bit <= (rsp_byte & STAT_BUSY_MASK) != 8'h00;
                        sh_done     <= 1'b1;
                        st_q        <= SH_IDLE;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/aai_seq_ctrl.sv
module aai_seq_ctrl
    import aai_prog_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int DEV_BYTES = 2097152,
    parameter int MAX_POLLS = 65536
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_data,
    output logic              go,
    output cmd_req_t          creq,
    input  logic              sh_done,
    input  logic              sh_busy_bit,
    output logic              done,
    output logic              err_range,
    output logic              err_timeout,
    output logic [LEN_W-1:0]  bytes_written
);

    localparam int EW     = 34;
    localparam int POLL_W = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
    localparam logic [EW-1:0]     DEV_LIM   = EW'(DEV_BYTES);
    localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(MAX_POLLS - 1);

    seq_state_e        st_q, after_q, post_q;
    phase_e            phase_q;
    cmd_kind_e         kind_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  rem_q, cnt_q;
    logic [1:0]        credit_q;
    logic [7:0]        d0_q, d1_q;
    logic              words_q;
    logic [POLL_W-1:0] polls_q;
    logic              err_range_q, err_to_q;
    logic [EW-1:0]     end_w;
    logic              range_bad;

    assign end_w     = EW'(req_addr) + EW'(req_len);
    assign range_bad = end_w > DEV_LIM;

    assign req_ready     = (st_q == S_IDLE);
    assign in_ready      = (st_q == S_GET_BYTE) || (st_q == S_GET0) || (st_q == S_GET1);
    assign go            = (st_q == S_ISSUE);
    assign done          = (st_q == S_DONE);
    assign creq          = '{kind: kind_q, addr: addr_q, d0: d0_q, d1: d1_q};
    assign err_range     = err_range_q;
    assign err_timeout   = err_to_q;
    assign bytes_written = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= S_IDLE;
            after_q     <= S_IDLE;
            post_q      <= S_IDLE;
            phase_q     <= PH_LEAD;
            kind_q      <= CK_WREN;
            addr_q      <= '0;
            rem_q       <= '0;
            cnt_q       <= '0;
            credit_q    <= '0;
            d0_q        <= '0;
            d1_q        <= '0;
            words_q     <= 1'b0;
            polls_q     <= '0;
            err_range_q <= 1'b0;
            err_to_q    <= 1'b0;
        end else begin
            case (st_q)
                S_IDLE: begin
                    if (req_valid) begin
                        addr_q      <= req_addr;
                        rem_q       <= req_len;
                        cnt_q       <= '0;
                        credit_q    <= '0;
                        words_q     <= 1'b0;
                        polls_q     <= '0;
                        phase_q     <= PH_LEAD;
                        err_to_q    <= 1'b0;
                        err_range_q <= range_bad;
                        st_q        <= range_bad ? S_DONE : S_PLAN;
                    end
                end
                S_PLAN: begin
                    case (phase_q)
                        PH_LEAD: begin
                            phase_q <= PH_WORD;
                            if (addr_q[0] && (rem_q != '0)) begin
                                kind_q  <= CK_WREN;
                                after_q <= S_GET_BYTE;
                                st_q    <= S_ISSUE;
                            end
                        end
                        PH_WORD: begin
                            if (rem_q >= LEN_W'(2)) begin
                                if (!words_q) begin
                                    kind_q  <= CK_WREN;
                                    after_q <= S_GET0;
                                    st_q    <= S_ISSUE;
                                end else begin
                                    st_q <= S_GET0;
                                end
                            end else begin
                                phase_q <= PH_TAIL;
                                if (words_q) begin
                                    kind_q   <= CK_WRDI;
                                    after_q  <= S_POLL_GO;
                                    post_q   <= S_PLAN;
                                    credit_q <= '0;
                                    st_q     <= S_ISSUE;
                                end
                            end
                        end
                        PH_TAIL: begin
                            if (rem_q != '0) begin
                                phase_q <= PH_FIN;
                                kind_q  <= CK_WREN;
                                after_q <= S_GET_BYTE;
                                st_q    <= S_ISSUE;
                            end else begin
                                st_q <= S_DONE;
                            end
                        end
                        default: begin
                            kind_q  <= CK_WRDI;
                            after_q <= S_DONE;
                            st_q    <= S_ISSUE;
                        end
                    endcase
                end
                S_ISSUE: st_q <= S_CMD;
                S_CMD: begin
                    if (sh_done) st_q <= after_q;
                end
                S_POLL_GO: begin
                    kind_q  <= CK_STAT;
                    after_q <= S_POLL_CHK;
                    st_q    <= S_ISSUE;
                end
                S_POLL_CHK: begin
                    if (!sh_busy_bit) begin
                        addr_q   <= addr_q + ADDR_W'(credit_q);
                        rem_q    <= rem_q - LEN_W'(credit_q);
                        cnt_q    <= cnt_q + LEN_W'(credit_q);
                        credit_q <= '0;
                        polls_q  <= '0;
                        st_q     <= post_q;
                    end else if (polls_q == POLL_LAST) begin
                        err_to_q <= 1'b1;
                        st_q     <= S_DONE;
                    end else begin
                        polls_q <= polls_q + 1'b1;
                        st_q    <= S_POLL_GO;
                    end
                end
                S_GET_BYTE: begin
                    if (in_valid) begin
                        d0_q     <= in_data;
                        kind_q   <= CK_BYTE;
                        credit_q <= 2'd1;
                        after_q  <= S_POLL_GO;
                        post_q   <= S_PLAN;
                        st_q     <= S_ISSUE;
                    end
                end
                S_GET0: begin
                    if (in_valid) begin
                        d0_q <= in_data;
                        st_q <= S_GET1;
                    end
                end
                S_GET1: begin
                    if (in_valid) begin
                        d1_q     <= in_data;
                        kind_q   <= words_q ? CK_WORD : CK_WORD_A;
                        words_q  <= 1'b1;
                        credit_q <= 2'd2;
                        after_q  <= S_POLL_GO;
                        post_q   <= S_PLAN;
                        st_q     <= S_ISSUE;
                    end
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/aai_word_programmer.sv
module aai_word_programmer
    import aai_prog_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int DEV_BYTES = 2097152,
    parameter int MAX_POLLS = 65536
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [23:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_data,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic [7:0]       cmd_byte,
    output logic             cmd_last,
    output logic             cmd_rd,
    input  logic             rsp_valid,
    input  logic [7:0]       rsp_byte,
    output logic             done,
    output logic             err_range,
    output logic             err_timeout,
    output logic [LEN_W-1:0] bytes_written
);

    logic     go;
    cmd_req_t creq;
    logic     sh_done;
    logic     sh_busy_bit;

    aai_seq_ctrl #(
        .LEN_W    (LEN_W),
        .DEV_BYTES(DEV_BYTES),
        .MAX_POLLS(MAX_POLLS)
    ) seq_i (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_addr     (req_addr),
        .req_len      (req_len),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_data      (in_data),
        .go           (go),
        .creq         (creq),
        .sh_done      (sh_done),
        .sh_busy_bit  (sh_busy_bit),
        .done         (done),
        .err_range    (err_range),
        .err_timeout  (err_timeout),
        .bytes_written(bytes_written)
    );

    aai_cmd_shifter shift_i (
        .clk        (clk),
        .rst        (rst),
        .go         (go),
        .req        (creq),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .cmd_byte   (cmd_byte),
        .cmd_last   (cmd_last),
        .cmd_rd     (cmd_rd),
        .rsp_valid  (rsp_valid),
        .rsp_byte   (rsp_byte),
        .sh_done    (sh_done),
        .sh_busy_bit(sh_busy_bit)
    );

endmodule

// File: rtl/aai_word_programmer_chk.sv
module aai_word_programmer_chk #(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic [LEN_W-1:0] req_len,
    input logic             in_ready,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic [7:0]       cmd_byte,
    input logic             cmd_last,
    input logic             cmd_rd,
    input logic             done,
    input logic             err_range,
    input logic             err_timeout,
    input logic [LEN_W-1:0] bytes_written
);

    logic [LEN_W-1:0] len_q;

    always_ff @(posedge clk) begin
        if (rst) len_q <= '0;
        else if (req_valid && req_ready) len_q <= req_len;
    end

    // R11: a stalled beat keeps its content
    p_beat_hold_r11: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_byte) && $stable(cmd_last) && $stable(cmd_rd));

    // R5: read slot is the final beat and carries 0x00
    p_read_slot_r5: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_rd |-> cmd_last && (cmd_byte == 8'h00));

    // R12: no traffic while idle
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !cmd_valid && !in_ready);

    // R12: done lasts one cycle and returns to idle
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && req_ready);

    // R12: error flags hold while idle
    p_err_hold_r12: assert property (@(posedge clk) disable iff (rst)
        req_ready && $past(req_ready) |-> $stable(err_range) && $stable(err_timeout));

    // R1: rejected request writes nothing
    p_range_clean_r1: assert property (@(posedge clk) disable iff (rst)
        done && err_range |-> (bytes_written == '0) && !err_timeout);

    // R9: count never falls during a request
    p_count_mono_r9: assert property (@(posedge clk) disable iff (rst)
        !req_ready && !$past(req_ready) |-> bytes_written >= $past(bytes_written));

    // R9: count never passes the accepted length
    p_count_bound_r9: assert property (@(posedge clk) disable iff (rst)
        !req_ready |-> bytes_written <= len_q);

endmodule

bind aai_word_programmer aai_word_programmer_chk #(.LEN_W(LEN_W)) chk_i (.*);

// File: tb/aai_word_programmer_tb_top.sv
module aai_word_programmer_tb_top;

    localparam int LEN_W = 16;
    localparam int DEV   = 4096;
    localparam int MAXP  = 6;
    localparam int NEVER = 1000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [23:0]      req_addr = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic             in_valid;
    logic             in_ready;
    logic [7:0]       in_data;
    logic             cmd_valid;
    logic             cmd_ready;
    logic [7:0]       cmd_byte;
    logic             cmd_last;
    logic             cmd_rd;
    logic             rsp_valid;
    logic [7:0]       rsp_byte;
    logic             done;
    logic             err_range;
    logic             err_timeout;
    logic [LEN_W-1:0] bytes_written;

    always #2 clk = ~clk;

    aai_word_programmer #(.LEN_W(LEN_W), .DEV_BYTES(DEV), .MAX_POLLS(MAXP)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_byte(cmd_byte),
        .cmd_last(cmd_last), .cmd_rd(cmd_rd), .rsp_valid(rsp_valid), .rsp_byte(rsp_byte),
        .done(done), .err_range(err_range), .err_timeout(err_timeout),
        .bytes_written(bytes_written)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [9:0] exp_q[$];
    logic [7:0] data_buf[$];
    int in_ptr = 0;
    int busy_cfg = 0, stall_from = NEVER, busy_left = 0, wait_idx = 0, rsp_cd = 0;
    int cyc = 0;
    bit ab;
    int wcount, credited;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Responder, stream source and per-clock beat comparison (R11 stream order)
    initial begin
        cmd_ready = 1'b0; in_valid = 1'b0; in_data = 8'h00;
        rsp_valid = 1'b0; rsp_byte = 8'h00;
        forever begin
            @(negedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_bad++;
                $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
            rsp_valid = 1'b0;
            if (rsp_cd > 0) begin
                rsp_cd--;
                if (rsp_cd == 0) begin
                    rsp_valid = 1'b1;
                    if (busy_left > 0) begin
                        rsp_byte = 8'h03;
                        busy_left--;
                    end else begin
                        rsp_byte = 8'h02;
                        wait_idx++;
                        busy_left = (wait_idx >= stall_from) ? 1000000 : busy_cfg;
                    end
                end
            end
            cmd_ready = (cyc % 5) != 3;
            if (!rst && cmd_valid && cmd_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R12 unexpected beat", {cmd_rd, cmd_last, cmd_byte}, 0);
                end else begin
                    logic [9:0] e;
                    e = exp_q.pop_front();
                    chk({cmd_rd, cmd_last, cmd_byte} == e, "R11 command beat",
                        {cmd_rd, cmd_last, cmd_byte}, e);
                end
                if (cmd_rd) rsp_cd = 2;
            end
            in_valid = (in_ptr < data_buf.size()) && ((cyc % 7) != 2);
            in_data  = (in_ptr < data_buf.size()) ? data_buf[in_ptr] : 8'h00;
            if (!rst && in_valid && in_ready) in_ptr++;
        end
    end

    task automatic push(input logic [7:0] b, input bit last, input bit rd);
        if (!ab) exp_q.push_back({rd, last, b});
    endtask

    task automatic put_addr(input int a);
        push(8'(a >> 16), 1'b0, 1'b0);
        push(8'(a >> 8), 1'b0, 1'b0);
        push(8'(a), 1'b0, 1'b0);
    endtask

    // R5: poll pattern; R8: abort after MAXP busy responses
    task automatic poll(input int credit);
        int n;
        if (ab) return;
        n = (wcount >= stall_from) ? 1000000 : busy_cfg;
        if (n < MAXP) begin
            for (int k = 0; k < n + 1; k++) begin
                push(8'h05, 1'b0, 1'b0);
                push(8'h00, 1'b1, 1'b1);
            end
            credited += credit;
            wcount++;
        end else begin
            for (int k = 0; k < MAXP; k++) begin
                push(8'h05, 1'b0, 1'b0);
                push(8'h00, 1'b1, 1'b1);
            end
            ab = 1'b1;
        end
    endtask

    task automatic build(input int a0, input int len);
        int a, i;
        bit first;
        a = a0; i = 0; ab = 1'b0; wcount = 0; credited = 0;
        exp_q.delete();
        if ((a % 2) == 1 && len > 0) begin            // R2 leading byte
            push(8'h06, 1'b1, 1'b0);
            push(8'h02, 1'b0, 1'b0); put_addr(a); push(data_buf[0], 1'b1, 1'b0);
            poll(1);
            a++; i++;
        end
        if (len - i >= 2) begin                        // R3 R4 words, R6 disable
            push(8'h06, 1'b1, 1'b0);
            first = 1'b1;
            while (len - i >= 2) begin
                push(8'hAD, 1'b0, 1'b0);
                if (first) put_addr(a);
                push(data_buf[i], 1'b0, 1'b0);
                push(data_buf[i+1], 1'b1, 1'b0);
                poll(2);
                first = 1'b0; i += 2; a += 2;
            end
            push(8'h04, 1'b1, 1'b0);
            poll(0);
        end
        if (len - i == 1) begin                        // R7 trailing byte
            push(8'h06, 1'b1, 1'b0);
            push(8'h02, 1'b0, 1'b0); put_addr(a); push(data_buf[i], 1'b1, 1'b0);
            poll(1);
            push(8'h04, 1'b1, 1'b0);
        end
    endtask

    task automatic run(input int a, input int len, input int busy, input int stall,
                       input bit exp_range, input string tag);
        @(negedge clk);
        data_buf.delete();
        for (int k = 0; k < len; k++) data_buf.push_back(8'(a * 7 + k * 13 + 5));
        in_ptr = 0;
        busy_cfg = busy; stall_from = stall; wait_idx = 0;
        busy_left = (stall <= 0) ? 1000000 : busy;
        if (exp_range) begin
            exp_q.delete(); ab = 1'b0; credited = 0;
        end else begin
            build(a, len);
        end
        req_valid = 1'b1; req_addr = 24'(a); req_len = LEN_W'(len);
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        chk(err_range == exp_range, {tag, " err_range"}, err_range, exp_range);
        chk(err_timeout == ab, {tag, " err_timeout"}, err_timeout, ab);
        chk(bytes_written == LEN_W'(credited), {tag, " bytes_written"}, bytes_written, credited);
        chk(exp_q.size() == 0, {tag, " beats left"}, exp_q.size(), 0);
        if (!ab) chk(in_ptr == (exp_range ? 0 : len), {tag, " data taken"}, in_ptr, exp_range ? 0 : len);
        @(negedge clk);
        chk(req_ready == 1'b1 && done == 1'b0, "R12 idle after done", {req_ready, done}, 2'b10);
        repeat (3) @(negedge clk);
        chk(err_range == exp_range && err_timeout == ab, "R12 flags held", {err_range, err_timeout},
            {exp_range, ab});
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R12 reset req_ready", req_ready, 1);
        chk(cmd_valid == 1'b0 && in_ready == 1'b0, "R12 reset quiet", {cmd_valid, in_ready}, 0);
        chk(done == 1'b0 && bytes_written == '0, "R9 reset count", bytes_written, 0);
        chk(err_range == 1'b0 && err_timeout == 1'b0, "R12 reset flags", {err_range, err_timeout}, 0);

        run(16, 6, 0, NEVER, 1'b0, "R3 R4 R6 even body");
        run(33, 5, 1, NEVER, 1'b0, "R2 R5 odd start");
        run(64, 3, 2, NEVER, 1'b0, "R7 trailing byte");
        run(101, 4, 0, NEVER, 1'b0, "R2 R7 both ends");
        run(7, 1, 0, NEVER, 1'b0, "R2 R6 lead only");
        run(200, 1, 3, NEVER, 1'b0, "R7 tail only");
        run(300, 0, 0, NEVER, 1'b0, "R10 zero length");
        run(4090, 7, 0, NEVER, 1'b1, "R1 past end");
        run(4090, 6, 0, NEVER, 1'b0, "R1 exact end");
        run(501, 9, 5, NEVER, 1'b0, "R5 long busy");
        run(40, 8, 0, 2, 1'b0, "R8 R9 timeout mid body");
        run(41, 3, 1, 0, 1'b0, "R8 timeout first poll");
        run(128, 4, 1, NEVER, 1'b0, "R12 recovery");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule